// File: doc/BRIEF.md
# Inbound Address Translation Region Set

This block translates addresses arriving from the PCIe side into addresses on the AXI side. It holds a small set of programmable regions. Each region has one range word and a group of map windows. The range word gives a PCIe base address and, in its low bits, a one-hot size selector. The map windows cut the region into equal parts. Each part carries its own AXI base and its own valid flag.

Software fills the registers through a write-only configuration port. The datapath takes one address per request. One clock later it reports four things: whether the address hit, which region and sub-window were chosen, the translated AXI address, and whether the region is tagged as I/O or memory. Overlapping regions are allowed. The region with the lowest index always wins.

Top module: `ib_xlate`

## Requirements
- R1: After reset no result is valid. The hit flag is low. Every range and map word is zero, so no region is in use.
- R2: A request raised on `t_req` at one rising edge gives `res_valid` high after that edge. `res_valid` is low after any edge at which `t_req` was low.
- R3: Bits [NUM_SIZES-1:0] of a range word form the size selector. Bit k selects a region size of 2^(MIN_LOG2+k) bytes. A range word whose selector bits are all zero marks the region unused, and an unused region never hits.
- R4: When more than one selector bit is set, the lowest set bit decides the region size.
- R5: An address falls inside a region when all its bits at and above the region size match the same bits of the range word. Range-word bits below the region size do not affect matching.
- R6: Each region is split into 2^WIN_LOG2 equal sub-windows. The sub-window index is the WIN_LOG2 address bits directly below the region size, and it is reported on `res_win`.
- R7: Bit 0 of a map word is its valid flag. On a hit, the translated address is the map word's bits at and above the sub-window size, joined with the request address bits below the sub-window size. Map-word bits below the sub-window size do not affect the result.
- R8: If the selected sub-window's valid flag is clear, the request is reported as a miss.
- R9: When several in-use regions match, the lowest-index region is selected. If that region's sub-window is invalid, the result is a miss, even when a higher-index region also covers the address.
- R10: On a hit, `res_io` equals the bit of `REGION_IO_MASK` for the selected region.
- R11: On a miss, `res_region`, `res_win`, `res_axi` and `res_io` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_map | input | 1 | Write target: 0 selects the range word, 1 selects a map word |
| cfg_region | input | RW | Region index of the write |
| cfg_win | input | WW | Sub-window index of a map write |
| cfg_wdata | input | ADDR_W | Data of the write |
| t_req | input | 1 | Translation request |
| t_addr | input | ADDR_W | PCIe-side address to translate |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | Translation hit |
| res_region | output | RW | Selected region |
| res_win | output | WW | Selected sub-window |
| res_axi | output | ADDR_W | Translated AXI address |
| res_io | output | 1 | Selected region is tagged as I/O |

## Verification
A wrong size decode or a wrong selector priority moves a region's edges. That shows up on `res_hit` for addresses close to a region boundary in the very cycle after the request. A wrong sub-window split shows up as a wrong `res_win` and a wrong upper part of `res_axi` in the same cycle. A broken overlap priority shows up as the wrong `res_region` and `res_io`. For this reason the address sweeps cross every region edge and every sub-window edge, and they also cover overlapped ranges and invalid windows.

// File: rtl/ib_xlate_pkg.sv
package ib_xlate_pkg;

  // Mask with every bit at or above position lg set
  function automatic logic [63:0] hi_mask(input logic [7:0] lg);
    if (lg >= 8'd64) return 64'd0;
    return ~((64'd1 << lg) - 64'd1);
  endfunction

  // Upper part taken from base, lower part taken from off, split at position lg
  function automatic logic [63:0] splice(input logic [63:0] base,
                                         input logic [63:0] off,
                                         input logic [7:0]  lg);
    return (base & hi_mask(lg)) | (off & ~hi_mask(lg));
  endfunction

endpackage

// File: rtl/ib_region_match.sv
module ib_region_match #(
  parameter int ADDR_W    = 32,
  parameter int NUM_SIZES = 4,
  parameter int MIN_LOG2  = 12,
  parameter int WIN_LOG2  = 1,
  localparam int WW = (WIN_LOG2 > 0) ? WIN_LOG2 : 1
) (
  input  logic [ADDR_W-1:0] rng_word,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_use,
  output logic              match,
  output logic [WW-1:0]     win_idx,
  output logic [7:0]        region_lg
);
  import ib_xlate_pkg::*;

  int          size_idx;
  logic [63:0] a64, r64, shifted;

  always_comb begin
    size_idx = 0;
    for (int k = NUM_SIZES - 1; k >= 0; k--)
      if (rng_word[k]) size_idx = k;
    in_use    = |rng_word[NUM_SIZES-1:0];
    region_lg = 8'(MIN_LOG2 + size_idx);
    a64       = 64'(addr);
    r64       = 64'(rng_word);
    match     = in_use && (((a64 ^ r64) & hi_mask(region_lg)) == 64'd0);
    shifted   = a64 >> (region_lg - 8'(WIN_LOG2));
    win_idx   = (WIN_LOG2 > 0) ? shifted[WW-1:0] : '0;
  end

endmodule

// File: rtl/ib_prio_pick.sv
module ib_prio_pick #(
  parameter int N  = 3,
  parameter int SW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [SW-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) sel = SW'(i);
    any = |req;
  end
endmodule

// File: rtl/ib_xlate.sv
module ib_xlate #(
  parameter int NUM_REGIONS = 3,
  parameter int NUM_SIZES   = 4,
  parameter int MIN_LOG2    = 12,
  parameter int WIN_LOG2    = 1,
  parameter int ADDR_W      = 32,
  parameter logic [NUM_REGIONS-1:0] REGION_IO_MASK = 1,
  localparam int RW      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int WW      = (WIN_LOG2 > 0) ? WIN_LOG2 : 1,
  localparam int NUM_WIN = 1 << WIN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel_map,
  input  logic [RW-1:0]     cfg_region,
  input  logic [WW-1:0]     cfg_win,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              t_req,
  input  logic [ADDR_W-1:0] t_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [RW-1:0]     res_region,
  output logic [WW-1:0]     res_win,
  output logic [ADDR_W-1:0] res_axi,
  output logic              res_io
);
  import ib_xlate_pkg::*;

  logic [ADDR_W-1:0] rng_q [NUM_REGIONS];
  logic [ADDR_W-1:0] map_q [NUM_REGIONS][NUM_WIN];

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        rng_q[r] <= '0;
        for (int w = 0; w < NUM_WIN; w++) map_q[r][w] <= '0;
      end
    end else if (cfg_we) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (cfg_region == RW'(r)) begin
          if (!cfg_sel_map) rng_q[r] <= cfg_wdata;
          for (int w = 0; w < NUM_WIN; w++)
            if (cfg_sel_map && cfg_win == WW'(w)) map_q[r][w] <= cfg_wdata;
        end
      end
    end
  end

  // Per-region range decode
  logic [NUM_REGIONS-1:0] match_vec, inuse_vec;
  logic [WW-1:0]          win_a [NUM_REGIONS];
  logic [7:0]             lg_a  [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    ib_region_match #(
      .ADDR_W(ADDR_W), .NUM_SIZES(NUM_SIZES),
      .MIN_LOG2(MIN_LOG2), .WIN_LOG2(WIN_LOG2)
    ) u_match (
      .rng_word (rng_q[g]),
      .addr     (t_addr),
      .in_use   (inuse_vec[g]),
      .match    (match_vec[g]),
      .win_idx  (win_a[g]),
      .region_lg(lg_a[g])
    );
  end

  logic          any_match;
  logic [RW-1:0] sel_region;

  ib_prio_pick #(.N(NUM_REGIONS), .SW(RW)) u_pick (
    .req(match_vec), .any(any_match), .sel(sel_region)
  );

  // Window selection and address splice
  logic [WW-1:0]     sel_win;
  logic [7:0]        sel_lg, win_lg;
  logic [ADDR_W-1:0] sel_word, axi_next;
  logic              sel_io, hit_next;

  always_comb begin
    sel_win  = '0;
    sel_lg   = 8'd0;
    sel_word = '0;
    sel_io   = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (sel_region == RW'(r)) begin
        sel_win = win_a[r];
        sel_lg  = lg_a[r];
        sel_io  = REGION_IO_MASK[r];
        for (int w = 0; w < NUM_WIN; w++)
          if (sel_win == WW'(w)) sel_word = map_q[r][w];
      end
    end
    win_lg   = sel_lg - 8'(WIN_LOG2);
    hit_next = t_req && any_match && sel_word[0];
    axi_next = ADDR_W'(splice(64'(sel_word), 64'(t_addr), win_lg));
  end

  // Result stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_region <= '0;
      res_win    <= '0;
      res_axi    <= '0;
      res_io     <= 1'b0;
    end else begin
      res_valid  <= t_req;
      res_hit    <= hit_next;
      res_region <= hit_next ? sel_region : '0;
      res_win    <= hit_next ? sel_win    : '0;
      res_axi    <= hit_next ? axi_next   : '0;
      res_io     <= hit_next && sel_io;
    end
  end

endmodule

// File: rtl/ib_xlate_chk.sv
module ib_xlate_chk #(
  parameter int NUM_REGIONS = 3,
  parameter int ADDR_W      = 32,
  parameter int RW          = 2,
  parameter int WW          = 1,
  parameter logic [NUM_REGIONS-1:0] IO_MASK = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   t_req,
  input logic                   res_valid,
  input logic                   res_hit,
  input logic [RW-1:0]          res_region,
  input logic [WW-1:0]          res_win,
  input logic [ADDR_W-1:0]      res_axi,
  input logic                   res_io,
  input logic [NUM_REGIONS-1:0] match_vec,
  input logic [NUM_REGIONS-1:0] inuse_vec
);
  logic [NUM_REGIONS-1:0] match_d, inuse_d, below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_d <= '0;
      inuse_d <= '0;
    end else begin
      match_d <= match_vec;
      inuse_d <= inuse_vec;
    end
  end

  always_comb
    for (int i = 0; i < NUM_REGIONS; i++) below[i] = (RW'(i) < res_region);

  // R2
  req_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_req |=> res_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !t_req |=> !res_valid);
  // R8
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);
  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_axi == '0 && res_region == '0 && res_win == '0 && !res_io));
  // R9
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (match_d[res_region] && ((match_d & below) == '0)));
  // R3
  used_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> inuse_d[res_region]);
  // R10
  io_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_io == IO_MASK[res_region]));

endmodule

bind ib_xlate ib_xlate_chk #(
  .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .RW(RW), .WW(WW),
  .IO_MASK(REGION_IO_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .t_req(t_req), .res_valid(res_valid),
  .res_hit(res_hit), .res_region(res_region), .res_win(res_win),
  .res_axi(res_axi), .res_io(res_io), .match_vec(match_vec),
  .inuse_vec(inuse_vec)
);

// File: tb/ib_xlate_test.sv
module ib_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 3;
  localparam int MINL = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel_map = 1'b0;
  logic [1:0]  cfg_region = '0;
  logic [0:0]  cfg_win = '0;
  logic [31:0] cfg_wdata = '0;
  logic        t_req = 1'b0;
  logic [31:0] t_addr = '0;
  logic        res_valid, res_hit, res_io;
  logic [1:0]  res_region;
  logic [0:0]  res_win;
  logic [31:0] res_axi;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  longint rng_m [NR];
  longint map_m [NR][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ib_xlate #(.NUM_REGIONS(3), .NUM_SIZES(4), .MIN_LOG2(12), .WIN_LOG2(1),
             .ADDR_W(32), .REGION_IO_MASK(3'b100)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel_map(cfg_sel_map),
    .cfg_region(cfg_region), .cfg_win(cfg_win), .cfg_wdata(cfg_wdata),
    .t_req(t_req), .t_addr(t_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_region(res_region), .res_win(res_win), .res_axi(res_axi), .res_io(res_io)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic wr(input bit is_map, input int r, input int w, input longint d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel_map = is_map; cfg_region = 2'(r);
    cfg_win = 1'(w); cfg_wdata = d[31:0];
    if (is_map) map_m[r][w] = d; else rng_m[r] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Expected result, computed from the requirement text by division
  task automatic model(input longint a, output bit eh, output int er,
                       output int ew, output longint ex, output bit eio);
    int pick = -1;
    eh = 0; er = 0; ew = 0; ex = 0; eio = 0;
    for (int r = 0; r < NR; r++) begin
      int k = -1;
      longint sz;
      for (int b = 3; b >= 0; b--) if (((rng_m[r] >> b) & 1) == 1) k = b;
      if (k < 0 || pick >= 0) continue;
      sz = longint'(1) << (MINL + k);
      if (a / sz == rng_m[r] / sz) begin
        longint wsz = sz / 2;
        int w = int'((a % sz) / wsz);
        pick = r;
        if (map_m[r][w] % 2 == 1) begin
          eh = 1; er = r; ew = w; eio = (r == 2);
          ex = (map_m[r][w] / wsz) * wsz + a % wsz;
        end
      end
    end
  endtask

  task automatic look(input longint a, input string tag);
    bit eh, eio; int er, ew; longint ex;
    model(a, eh, er, ew, ex, eio);
    @(negedge clk);
    t_req = 1'b1; t_addr = a[31:0];
    @(negedge clk);
    t_req = 1'b0;
    check(res_valid === 1'b1, "R2",
          $sformatf("valid addr=%h act=%b exp=1", a, res_valid));
    check(res_hit === eh && res_region === 2'(er) && res_win === 1'(ew) &&
          res_axi === ex[31:0] && res_io === eio, tag,
          $sformatf("addr=%h act hit=%b reg=%0d win=%0d axi=%h io=%b exp hit=%b reg=%0d win=%0d axi=%h io=%b",
                    a, res_hit, res_region, res_win, res_axi, res_io,
                    eh, er, ew, ex[31:0], eio));
    @(negedge clk);
    check(res_valid === 1'b0, "R2",
          $sformatf("idle valid act=%b exp=0", res_valid));
  endtask

  task automatic sweep(input longint lo, input longint hi, input longint step,
                       input string tag);
    for (longint a = lo; a < hi; a += step) look(a, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      rng_m[r] = 0; map_m[r][0] = 0; map_m[r][1] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(res_valid === 1'b0 && res_hit === 1'b0 && res_axi === 32'd0, "R1",
          $sformatf("reset act valid=%b hit=%b axi=%h exp 0 0 0",
                    res_valid, res_hit, res_axi));
    // R1 / R3: nothing programmed, every lookup misses
    sweep(64'h0, 64'h20000, 64'h1000, "R3");

    // R5 R6 R7: 4 KB region, map base low bits are ignored
    wr(0, 0, 0, 64'h0001_0001);
    wr(1, 0, 0, 64'h8000_0001);
    wr(1, 0, 1, 64'h9000_0041);
    sweep(64'hF000, 64'h12000, 64'h100, "R5");
    look(64'h10A34, "R7");
    look(64'h107FF, "R6");
    look(64'h10800, "R6");

    // R8: 32 KB region with an invalid upper window; base low bits ignored (R5)
    wr(0, 1, 0, 64'h0002_0308);
    wr(1, 1, 0, 64'hA000_0001);
    wr(1, 1, 1, 64'hB000_0000);
    sweep(64'h18000, 64'h2A000, 64'h400, "R8");

    // R9 R10: I/O region 2 (8 KB) overlaps region 0
    wr(0, 2, 0, 64'h0001_0002);
    wr(1, 2, 0, 64'hC000_0001);
    wr(1, 2, 1, 64'hD000_0001);
    sweep(64'hF000, 64'h13000, 64'h200, "R9");
    look(64'h11234, "R10");

    // R9: region 0 window 0 invalid blocks region 2 underneath it
    wr(1, 0, 0, 64'h8000_0000);
    sweep(64'h10000, 64'h12000, 64'h400, "R9");

    // R4: two selector bits, lowest (8 KB) rules
    wr(0, 1, 0, 64'h0004_0006);
    wr(1, 1, 1, 64'hE000_0001);
    sweep(64'h3F000, 64'h44000, 64'h200, "R4");
    look(64'h42000, "R4");

    // R3: clearing the selector disables region 2
    wr(0, 2, 0, 64'h0001_0000);
    sweep(64'h10000, 64'h12000, 64'h400, "R3");

    // R11: a miss reports all-zero side fields
    look(64'h7_0000, "R11");

    summary();
  end
endmodule